// File: doc/BRIEF.md
# Protected Fully Associative Translation Buffer

This block caches recent virtual-to-physical page translations for one requester. Every slot remembers a virtual page number, the owning process, the physical page, and a set of page attributes: whether the page is resident, whether it may only be read, and whether only privileged code may touch it. A lookup carries a virtual page number, the running process, a read/write flag and a user/privileged flag. All slots are compared in parallel. One cycle later the block answers with exactly one of three outcomes: a hit with the physical page, a miss, or a fault with a code that gives its cause.

Each slot also keeps usage history. A successful translation marks the slot as referenced, and a successful write also marks it as modified. The response reports the history the slot had before the access. A page-table walker outside the block loads slots through a refill port. Refill reuses a slot that already holds the same page and process. If there is none, it takes a free slot, and if every slot is full it takes the slot under a rotating pointer. Software can drop every slot at once, or only the slots of one process, for example when an address space is torn down.

Top module: `tlb_prot`

## Requirements
- R1: When `lk_req` is high at a clock edge, `rsp_valid` is high after that edge with exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` set. When `lk_req` is low, all four are low after the edge.
- R2: A lookup hits only a valid slot whose page number and process ID both equal the request. A hit drives that slot's physical page on `rsp_ppn`. Any other lookup is a miss.
- R3: A lookup that finds a slot marked not resident faults with `rsp_fault_kind` = 1, whatever the other attributes, the access type and the mode. `rsp_fault_kind` is 0 whenever no fault is reported.
- R4: A user-mode lookup (`lk_user`=1) that finds a resident privileged-only slot faults with `rsp_fault_kind` = 2.
- R5: A write (`lk_write`=1) that finds a resident read-only slot, and passes the privilege check, faults with `rsp_fault_kind` = 3. A privileged access to a privileged-only page succeeds, and so does a read of a read-only page.
- R6: A hit sets the slot's referenced bit, and a write hit also sets its modified bit. A fault changes neither bit. `rsp_was_ref` and `rsp_was_mod` give the slot's bits as they were before the hit.
- R7: A refill whose page and process match a valid slot overwrites that slot. Otherwise it fills the lowest-numbered invalid slot. If all slots are valid, it replaces the slot under a victim pointer. The pointer starts at 0 and advances by one, wrapping modulo the slot count, only on such a replacement. A refilled slot starts with its referenced and modified bits clear.
- R8: `flush_all` invalidates every slot at the clock edge where it is sampled.
- R9: `flush_pid_en` invalidates, at that edge, exactly the slots whose process ID equals `flush_pid`.
- R10: A lookup is answered from the contents before any refill or flush sampled at the same edge. A flush sampled at the same edge as a refill also removes the refilled slot if that slot is selected by the flush.
- R11: After reset every slot is invalid, no response is presented, and the victim pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_pid | input | PID_W | Process ID of the requester |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user mode, 0 = privileged mode |
| fill_en | input | 1 | Refill strobe |
| fill_vpn | input | VPN_W | Virtual page of the new slot |
| fill_pid | input | PID_W | Process ID of the new slot |
| fill_ppn | input | PPN_W | Physical page of the new slot |
| fill_present | input | 1 | Page is resident |
| fill_ro | input | 1 | Page is read-only |
| fill_priv | input | 1 | Page is privileged-only |
| flush_all | input | 1 | Invalidate all slots |
| flush_pid_en | input | 1 | Invalidate slots owned by `flush_pid` |
| flush_pid | input | PID_W | Process ID selected for invalidation |
| rsp_valid | output | 1 | A lookup response is presented |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No matching slot |
| rsp_fault | output | 1 | Matching slot refused the access |
| rsp_fault_kind | output | 2 | 0 none, 1 not resident, 2 privilege, 3 write-protect |
| rsp_ppn | output | PPN_W | Physical page on a hit, otherwise 0 |
| rsp_was_ref | output | 1 | Referenced bit before this hit |
| rsp_was_mod | output | 1 | Modified bit before this hit |

## Verification
A lookup can be sampled at the same edge as a refill or a flush, and a flush can be sampled together with a refill. The bench drives these pairs in one cycle. It checks that a lookup sampled with `flush_all` still hits on the old contents while the next lookup misses. It checks that a lookup of a page being refilled at that edge misses. It also checks that a process flush removes a refill of the same process in that cycle but leaves a refill of another process in place.

// File: rtl/tlb_prot_pkg.sv
package tlb_prot_pkg;

    // Cause reported with a refused translation; the order also sets priority
    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PRIV   = 2'd2,
        FLT_WPROT  = 2'd3
    } fault_e;

endpackage

// File: rtl/tlb_prot_cam.sv
// Parallel comparison of one key against every slot tag.
module tlb_prot_cam #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PID_W = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [VPN_W-1:0] key_vpn,
    input  logic [PID_W-1:0] key_pid,
    input  logic [VPN_W-1:0] ent_vpn [N],
    input  logic [PID_W-1:0] ent_pid [N],
    input  logic [N-1:0]     ent_valid,
    output logic [N-1:0]     match,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = ent_valid[g] && (ent_vpn[g] == key_vpn) && (ent_pid[g] == key_pid);
    end

    assign any = |match;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_prot_victim.sv
// Picks the slot that a refill writes.
module tlb_prot_victim #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid,
    input  logic [IDX_W-1:0] ptr,
    input  logic             same_any,
    input  logic [IDX_W-1:0] same_idx,
    output logic [IDX_W-1:0] vic_idx,
    output logic             vic_from_ptr
);

    logic             free_any;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign free_any = ~&valid;

    always_comb begin
        if (same_any) begin
            vic_idx      = same_idx;
            vic_from_ptr = 1'b0;
        end else if (free_any) begin
            vic_idx      = free_idx;
            vic_from_ptr = 1'b0;
        end else begin
            vic_idx      = ptr;
            vic_from_ptr = 1'b1;
        end
    end

endmodule

// File: rtl/tlb_prot.sv
module tlb_prot
    import tlb_prot_pkg::*;
#(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PID_W = 8,
    parameter int PPN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [PID_W-1:0] lk_pid,
    input  logic             lk_write,
    input  logic             lk_user,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PID_W-1:0] fill_pid,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_present,
    input  logic             fill_ro,
    input  logic             fill_priv,
    input  logic             flush_all,
    input  logic             flush_pid_en,
    input  logic [PID_W-1:0] flush_pid,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [1:0]       rsp_fault_kind,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             rsp_was_ref,
    output logic             rsp_was_mod
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PID_W-1:0] pid;
        logic [PPN_W-1:0] ppn;
        logic             present;
        logic             ro;
        logic             priv;
        logic             refd;
        logic             modd;
    } slot_t;

    typedef struct packed {
        slot_t [N-1:0]    slot;
        logic [IDX_W-1:0] ptr;
        logic             rv;
        logic             hit;
        logic             miss;
        logic             fault;
        fault_e           kind;
        logic [PPN_W-1:0] ppn;
        logic             was_ref;
        logic             was_mod;
    } state_t;

    state_t s_d, s_q;

    logic [VPN_W-1:0] ent_vpn [N];
    logic [PID_W-1:0] ent_pid [N];
    logic [N-1:0]     valid_vec;

    for (genvar g = 0; g < N; g++) begin : g_view
        assign ent_vpn[g]   = s_q.slot[g].vpn;
        assign ent_pid[g]   = s_q.slot[g].pid;
        assign valid_vec[g] = s_q.slot[g].valid;
    end

    logic [N-1:0]     lk_match, fill_match;
    logic             lk_any, fill_any;
    logic [IDX_W-1:0] lk_idx, fill_idx;
    logic [IDX_W-1:0] vic_idx;
    logic             vic_from_ptr;

    tlb_prot_cam #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_lk (
        .key_vpn  (lk_vpn),
        .key_pid  (lk_pid),
        .ent_vpn  (ent_vpn),
        .ent_pid  (ent_pid),
        .ent_valid(valid_vec),
        .match    (lk_match),
        .any      (lk_any),
        .idx      (lk_idx)
    );

    tlb_prot_cam #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_fill (
        .key_vpn  (fill_vpn),
        .key_pid  (fill_pid),
        .ent_vpn  (ent_vpn),
        .ent_pid  (ent_pid),
        .ent_valid(valid_vec),
        .match    (fill_match),
        .any      (fill_any),
        .idx      (fill_idx)
    );

    tlb_prot_victim #(.N(N)) u_victim (
        .valid       (valid_vec),
        .ptr         (s_q.ptr),
        .same_any    (fill_any),
        .same_idx    (fill_idx),
        .vic_idx     (vic_idx),
        .vic_from_ptr(vic_from_ptr)
    );

    always_comb begin
        s_d = s_q;

        // Lookup, judged against the registered contents
        s_d.rv      = lk_req;
        s_d.hit     = 1'b0;
        s_d.miss    = 1'b0;
        s_d.fault   = 1'b0;
        s_d.kind    = FLT_NONE;
        s_d.ppn     = '0;
        s_d.was_ref = 1'b0;
        s_d.was_mod = 1'b0;
        if (lk_req) begin
            if (!lk_any) begin
                s_d.miss = 1'b1;
            end else if (!s_q.slot[lk_idx].present) begin
                s_d.fault = 1'b1;
                s_d.kind  = FLT_ABSENT;
            end else if (lk_user && s_q.slot[lk_idx].priv) begin
                s_d.fault = 1'b1;
                s_d.kind  = FLT_PRIV;
            end else if (lk_write && s_q.slot[lk_idx].ro) begin
                s_d.fault = 1'b1;
                s_d.kind  = FLT_WPROT;
            end else begin
                s_d.hit                 = 1'b1;
                s_d.ppn                 = s_q.slot[lk_idx].ppn;
                s_d.was_ref             = s_q.slot[lk_idx].refd;
                s_d.was_mod             = s_q.slot[lk_idx].modd;
                s_d.slot[lk_idx].refd   = 1'b1;
                if (lk_write) s_d.slot[lk_idx].modd = 1'b1;
            end
        end

        // Refill overrides the status update of the same slot
        if (fill_en) begin
            s_d.slot[vic_idx].valid   = 1'b1;
            s_d.slot[vic_idx].vpn     = fill_vpn;
            s_d.slot[vic_idx].pid     = fill_pid;
            s_d.slot[vic_idx].ppn     = fill_ppn;
            s_d.slot[vic_idx].present = fill_present;
            s_d.slot[vic_idx].ro      = fill_ro;
            s_d.slot[vic_idx].priv    = fill_priv;
            s_d.slot[vic_idx].refd    = 1'b0;
            s_d.slot[vic_idx].modd    = 1'b0;
            if (vic_from_ptr) begin
                s_d.ptr = (s_q.ptr == LAST) ? '0 : s_q.ptr + 1'b1;
            end
        end

        // Flushes act last so they also remove a same-cycle refill
        for (int i = 0; i < N; i++) begin
            if (flush_all || (flush_pid_en && (s_d.slot[i].pid == flush_pid))) begin
                s_d.slot[i].valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid      = s_q.rv;
    assign rsp_hit        = s_q.hit;
    assign rsp_miss       = s_q.miss;
    assign rsp_fault      = s_q.fault;
    assign rsp_fault_kind = s_q.kind;
    assign rsp_ppn        = s_q.ppn;
    assign rsp_was_ref    = s_q.was_ref;
    assign rsp_was_mod    = s_q.was_mod;

endmodule

// File: rtl/tlb_prot_chk.sv
module tlb_prot_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lk_req,
    input logic         flush_all,
    input logic         rsp_valid,
    input logic         rsp_hit,
    input logic         rsp_miss,
    input logic         rsp_fault,
    input logic [1:0]   rsp_fault_kind,
    input logic [N-1:0] valid_vec,
    input logic [N-1:0] lk_match
);

    assert_resp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    assert_no_spurious_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    assert_single_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

    assert_kind_with_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault == (rsp_fault_kind != 2'd0));

    assert_unique_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_vec == '0));

endmodule

bind tlb_prot tlb_prot_chk #(.N(N)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_req        (lk_req),
    .flush_all     (flush_all),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_miss      (rsp_miss),
    .rsp_fault     (rsp_fault),
    .rsp_fault_kind(rsp_fault_kind),
    .valid_vec     (valid_vec),
    .lk_match      (lk_match)
);

// File: tb/sim_tlb_prot.sv
`timescale 1ns/1ps
module sim_tlb_prot;

    localparam int N     = 16;
    localparam int VPN_W = 20;
    localparam int PID_W = 8;
    localparam int PPN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_req = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic [PID_W-1:0] lk_pid = '0;
    logic             lk_write = 1'b0;
    logic             lk_user = 1'b0;
    logic             fill_en = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PID_W-1:0] fill_pid = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic             fill_present = 1'b0;
    logic             fill_ro = 1'b0;
    logic             fill_priv = 1'b0;
    logic             flush_all = 1'b0;
    logic             flush_pid_en = 1'b0;
    logic [PID_W-1:0] flush_pid = '0;
    logic             rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [1:0]       rsp_fault_kind;
    logic [PPN_W-1:0] rsp_ppn;
    logic             rsp_was_ref, rsp_was_mod;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tlb_prot #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        lk_req = 1'b0; lk_write = 1'b0; lk_user = 1'b0;
        fill_en = 1'b0; flush_all = 1'b0; flush_pid_en = 1'b0;
    endtask

    // Outputs are read 1 ns after the edge that sampled the drive
    task automatic step();
        @(posedge clk);
        #1;
        clear_inputs();
    endtask

    task automatic set_lookup(input int vpn, input int pid, input bit wr, input bit usr);
        lk_req = 1'b1; lk_vpn = VPN_W'(vpn); lk_pid = PID_W'(pid);
        lk_write = wr; lk_user = usr;
    endtask

    task automatic set_fill(input int vpn, input int pid, input int ppn,
                            input bit pres, input bit ro, input bit priv);
        fill_en = 1'b1; fill_vpn = VPN_W'(vpn); fill_pid = PID_W'(pid);
        fill_ppn = PPN_W'(ppn); fill_present = pres; fill_ro = ro; fill_priv = priv;
    endtask

    task automatic lookup(input int vpn, input int pid, input bit wr, input bit usr);
        @(negedge clk);
        set_lookup(vpn, pid, wr, usr);
        step();
    endtask

    task automatic fill(input int vpn, input int pid, input int ppn,
                        input bit pres, input bit ro, input bit priv);
        @(negedge clk);
        set_fill(vpn, pid, ppn, pres, ro, priv);
        step();
    endtask

    task automatic exp_hit(input string req, input int ppn);
        chk(req, {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 32'b1100);
        chk(req, 32'(rsp_ppn), 32'(ppn));
    endtask

    task automatic exp_miss(input string req);
        chk(req, {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 32'b1010);
    endtask

    task automatic exp_fault(input string req, input int kind);
        chk(req, {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 32'b1001);
        chk(req, 32'(rsp_fault_kind), 32'(kind));
    endtask

    task automatic t_reset();
        chk("R11 no response after reset", {31'd0, rsp_valid}, 32'd0);
        lookup(0, 0, 0, 0);
        exp_miss("R11 empty after reset");
        lookup(32'h0_0100, 1, 0, 1);
        exp_miss("R11 empty after reset pid1");
    endtask

    task automatic t_basic();
        fill(32'h100, 1, 32'hAA, 1, 0, 0);
        lookup(32'h100, 1, 0, 1);
        exp_hit("R2 matching page and pid", 32'hAA);
        chk("R1 kind zero on hit", 32'(rsp_fault_kind), 0);
        step();
        chk("R1 idle cycle silent", {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 0);
        lookup(32'h100, 2, 0, 1);
        exp_miss("R2 other pid misses");
        lookup(32'h101, 1, 0, 1);
        exp_miss("R2 other page misses");
    endtask

    task automatic t_faults();
        fill(32'h200, 1, 32'h11, 0, 1, 1);
        lookup(32'h200, 1, 1, 1);
        exp_fault("R3 not resident wins", 1);
        lookup(32'h200, 1, 0, 0);
        exp_fault("R3 not resident privileged read", 1);
        fill(32'h300, 1, 32'h22, 1, 1, 1);
        lookup(32'h300, 1, 1, 1);
        exp_fault("R4 user write to privileged page", 2);
        lookup(32'h300, 1, 0, 1);
        exp_fault("R4 user read of privileged page", 2);
        lookup(32'h300, 1, 1, 0);
        exp_fault("R5 privileged write to read-only", 3);
        lookup(32'h300, 1, 0, 0);
        exp_hit("R5 privileged read allowed", 32'h22);
        fill(32'h400, 1, 32'h33, 1, 1, 0);
        lookup(32'h400, 1, 0, 1);
        exp_hit("R5 read of read-only allowed", 32'h33);
        lookup(32'h400, 1, 1, 1);
        exp_fault("R5 user write to read-only", 3);
    endtask

    task automatic t_status();
        fill(32'h500, 1, 32'h44, 1, 0, 0);
        lookup(32'h500, 1, 0, 1);
        exp_hit("R6 first read", 32'h44);
        chk("R6 fresh ref clear", {31'd0, rsp_was_ref}, 0);
        chk("R6 fresh mod clear", {31'd0, rsp_was_mod}, 0);
        lookup(32'h500, 1, 0, 1);
        chk("R6 ref set by read", {31'd0, rsp_was_ref}, 1);
        chk("R6 mod untouched by read", {31'd0, rsp_was_mod}, 0);
        lookup(32'h500, 1, 1, 1);
        chk("R6 mod clear before write", {31'd0, rsp_was_mod}, 0);
        lookup(32'h500, 1, 0, 1);
        chk("R6 mod set by write", {31'd0, rsp_was_mod}, 1);
        fill(32'h600, 1, 32'h55, 1, 1, 0);
        lookup(32'h600, 1, 1, 1);
        exp_fault("R6 faulting write", 3);
        lookup(32'h600, 1, 0, 1);
        chk("R6 fault left ref clear", {31'd0, rsp_was_ref}, 0);
        chk("R6 fault left mod clear", {31'd0, rsp_was_mod}, 0);
    endtask

    task automatic t_refill_same();
        fill(32'h100, 1, 32'hBB, 1, 0, 0);
        lookup(32'h100, 1, 0, 1);
        exp_hit("R7 refill overwrites same page", 32'hBB);
        chk("R7 refill clears ref", {31'd0, rsp_was_ref}, 0);
    endtask

    task automatic t_flush_pid();
        fill(32'h700, 2, 32'h66, 1, 0, 0);
        @(negedge clk);
        flush_pid_en = 1'b1; flush_pid = 8'd1;
        step();
        lookup(32'h700, 2, 0, 1);
        exp_hit("R9 other pid survives", 32'h66);
        lookup(32'h100, 1, 0, 1);
        exp_miss("R9 pid1 slot removed");
        lookup(32'h500, 1, 0, 1);
        exp_miss("R9 pid1 second slot removed");
    endtask

    task automatic t_flush_all();
        @(negedge clk);
        flush_all = 1'b1;
        step();
        lookup(32'h700, 2, 0, 1);
        exp_miss("R8 flush all removes slot");
    endtask

    task automatic t_replace();
        for (int i = 0; i < N - 1; i++) fill(32'h1000 + i, 3, 32'h100 + i, 1, 0, 0);
        fill(32'h1000 + N - 1, 4, 32'h1FF, 1, 0, 0);
        fill(32'h2000, 3, 32'h200, 1, 0, 0);
        lookup(32'h1000, 3, 0, 1);
        exp_miss("R7 pointer 0 replaced");
        lookup(32'h1001, 3, 0, 1);
        exp_hit("R7 slot 1 kept", 32'h101);
        lookup(32'h2000, 3, 0, 1);
        exp_hit("R7 new page resident", 32'h200);
        fill(32'h2001, 3, 32'h201, 1, 0, 0);
        lookup(32'h1001, 3, 0, 1);
        exp_miss("R7 pointer advanced to 1");
        @(negedge clk);
        flush_pid_en = 1'b1; flush_pid = 8'd4;
        step();
        fill(32'h3000, 3, 32'h300, 1, 0, 0);
        lookup(32'h1002, 3, 0, 1);
        exp_hit("R7 free slot preferred over pointer", 32'h102);
        lookup(32'h3000, 3, 0, 1);
        exp_hit("R7 free slot filled", 32'h300);
        fill(32'h3001, 3, 32'h301, 1, 0, 0);
        lookup(32'h1002, 3, 0, 1);
        exp_miss("R7 pointer at 2 after free fill");
        lookup(32'h1003, 3, 0, 1);
        exp_hit("R7 slot 3 kept", 32'h103);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        flush_all = 1'b1;
        step();
        fill(32'h800, 5, 32'h77, 1, 0, 0);
        @(negedge clk);
        set_lookup(32'h800, 5, 0, 1);
        flush_all = 1'b1;
        step();
        exp_hit("R10 lookup sees contents before flush", 32'h77);
        lookup(32'h800, 5, 0, 1);
        exp_miss("R10 flush effective afterwards");
        @(negedge clk);
        set_lookup(32'h900, 5, 0, 1);
        set_fill(32'h900, 5, 32'h88, 1, 0, 0);
        flush_pid_en = 1'b1; flush_pid = 8'd5;
        step();
        exp_miss("R10 lookup before same-cycle refill");
        lookup(32'h900, 5, 0, 1);
        exp_miss("R10 pid flush removes same-cycle refill");
        @(negedge clk);
        set_fill(32'h901, 6, 32'h99, 1, 0, 0);
        flush_pid_en = 1'b1; flush_pid = 8'd5;
        step();
        lookup(32'h901, 6, 0, 1);
        exp_hit("R10 refill of other pid survives", 32'h99);
    endtask

    initial begin
        #200_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_faults();
        t_status();
        t_refill_same();
        t_flush_pid();
        t_flush_all();
        t_replace();
        t_same_cycle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule